// File: doc/BRIEF.md
# Frame-Synced Serial Converter Host Controller

This block is the host side of a serial link to two analog-to-digital converters that sit on one shared serial clock. Each frame is opened by an active-low frame-sync. During the frame the block shifts a 32-bit command out on the shared data-in line, MSB first. In the same frame it captures one 32-bit word from each converter on that converter's own data-out line. The serial clock is the system clock divided by an even ratio. It runs only while frame-sync is low and is parked high at all other times.

Each converter presents its first bit as soon as frame-sync falls. It holds that bit through the first falling clock edge of the frame and moves to the next bit on each of the 31 falling edges that follow. The host takes each bit on the rising clock edge, in the middle of the bit. It changes its own data-in bit on the rising edge too, so that the bit is stable for half a clock period before the falling edge on which the converter reads it.

After reset the block runs a two-frame start-up on its own. The first frame writes the configuration word and the second sends a read command. The converters return their configuration contents in that second frame, and the block compares them with the value it wrote. When start-up is over, a host runs one frame at a time with a start pulse and waits for the done pulse.

Top module: `fs_adc_host`

## Requirements
- R1: While reset is held, frameSyncN, serClk and serDataOut are 1, 1 and 0, done, verifyPass and verifyFail are 0, and busy is 1 because start-up is pending.
- R2: One serial clock period is CLK_DIV system cycles, half high and half low. serClk is high whenever frameSyncN is high.
- R3: frameSyncN stays low for exactly 32 serial clock periods (32*CLK_DIV system cycles). The frame has exactly 32 falling serClk edges, and the first one comes half a period after frameSyncN falls.
- R4: After frameSyncN rises, it stays high for at least IDLE_GAP system cycles before the next frame.
- R5: The command goes out MSB first. Bit 31 appears when frameSyncN falls, and each later bit changes only on a rising serClk edge, so every bit is stable at the falling edge that follows.
- R6: Both data-out lines are sampled on rising serClk edges in the same frame. The MSB is the value present at the first rising edge. When done is asserted, rxWordA and rxWordB hold the two 32-bit words, MSB first.
- R7: A start pulse with busy low is accepted. cmdIn is latched at that edge. busy is high from the next cycle until done, and done is a one-cycle pulse in a cycle where busy is already low.
- R8: A start pulse while busy is high is ignored. No extra frame follows and the frame in flight still sends the latched command.
- R9: After reset the block sends CFG_WORD in one frame and READ_CMD in the next, with no done pulse, and only then drops busy.
- R10: When the read frame of start-up ends, verifyPass is set if both captured words equal CFG_WORD on the bits set in CFG_MASK. Otherwise verifyFail is set. The two flags are never high together, and the result holds until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame (single-cycle pulse) |
| cmdIn | input | 32 | Command word for the requested frame |
| busy | output | 1 | Start-up or a frame is in progress |
| done | output | 1 | One-cycle pulse when a requested frame is complete |
| rxWordA | output | 32 | Word captured from converter A |
| rxWordB | output | 32 | Word captured from converter B |
| serClk | output | 1 | Gated serial clock, parked high |
| frameSyncN | output | 1 | Active-low frame-sync |
| serDataOut | output | 1 | Command bit to both converters |
| serDataInA | input | 1 | Data from converter A |
| serDataInB | input | 1 | Data from converter B |
| verifyPass | output | 1 | Configuration readback matched |
| verifyFail | output | 1 | Configuration readback mismatched |

## Verification
The checks on clock parking, frame length, idle gap and data-in stability assume that start is a clean single-cycle pulse, synchronous to clk. They also assume that each data-out line changes only after frameSyncN falls or on a falling serClk edge, and is therefore settled at every rising edge. The bench's converter models change their lines only at those instants, from events on the block's own outputs. The bench drives start and cmdIn on the falling system clock edge. It asserts reset again only while the block is idle.

// File: rtl/fs_adc_host_pkg.sv
package fs_adc_host_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } ctrlState_t;

  typedef enum logic [1:0] {
    SRC_CFG  = 2'd0,
    SRC_READ = 2'd1,
    SRC_HOST = 2'd2
  } wordSrc_t;

  // strobes from control to datapath, valid for one system cycle
  typedef struct packed {
    logic     load;    // open a frame, load the command shifter
    wordSrc_t src;     // which command word to load
    logic     rise;    // serial clock rises on this edge: sample and shift
    logic     last;    // final rising edge of the frame
    logic     verify;  // last edge of the start-up read frame
  } ctrlStrobe_t;

endpackage

// File: rtl/fs_adc_host_ctrl.sv
module fs_adc_host_ctrl
  import fs_adc_host_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CLK_DIV  = 4,
  parameter int IDLE_GAP = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        frameSyncN,
  output logic        serClk,
  output logic        busy,
  output logic        done
);

  localparam int HALF    = CLK_DIV / 2;
  localparam int TC_W    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PH_W    = $clog2(2 * WORD_W + 1);
  localparam int GAP_W   = $clog2(IDLE_GAP + 1);
  localparam int LAST_PH = 2 * WORD_W;

  ctrlState_t       state;
  logic [TC_W-1:0]  tickCnt;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  nextPhase;
  logic [GAP_W-1:0] gapCnt;
  logic [1:0]       initStep;
  logic             hostXfer;
  logic             halfEnd;
  logic             initPending;
  logic             launchInit;
  logic             launchHost;

  assign initPending = (initStep != 2'd2);
  assign halfEnd     = (state == ST_FRAME) && (tickCnt == TC_W'(HALF - 1));
  assign nextPhase   = phase + 1'b1;
  assign launchInit  = (state == ST_IDLE) && initPending;
  assign launchHost  = (state == ST_IDLE) && !initPending && start;

  always_comb begin
    strobe        = '0;
    strobe.load   = launchInit || launchHost;
    strobe.src    = launchHost ? SRC_HOST : ((initStep == 2'd0) ? SRC_CFG : SRC_READ);
    strobe.rise   = halfEnd && !nextPhase[0];
    strobe.last   = halfEnd && (nextPhase == PH_W'(LAST_PH));
    strobe.verify = strobe.last && !hostXfer && (initStep == 2'd1);
  end

  assign busy = (state != ST_IDLE) || initPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tickCnt    <= '0;
      phase      <= '0;
      gapCnt     <= '0;
      initStep   <= 2'd0;
      hostXfer   <= 1'b0;
      frameSyncN <= 1'b1;
      serClk     <= 1'b1;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (strobe.load) begin
            state      <= ST_FRAME;
            tickCnt    <= '0;
            phase      <= '0;
            frameSyncN <= 1'b0;
            hostXfer   <= launchHost;
          end
        end
        ST_FRAME: begin
          if (halfEnd) begin
            tickCnt <= '0;
            phase   <= nextPhase;
            serClk  <= ~nextPhase[0];  // odd half-phases low, even high
            if (strobe.last) begin
              state      <= ST_GAP;
              gapCnt     <= '0;
              frameSyncN <= 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(IDLE_GAP - 1)) begin
            state    <= ST_IDLE;
            done     <= hostXfer;
            hostXfer <= 1'b0;
            if (initPending) initStep <= initStep + 1'b1;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fs_adc_host_dp.sv
module fs_adc_host_dp
  import fs_adc_host_pkg::*;
#(
  parameter int              WORD_W   = 32,
  parameter int              NUM_CH   = 2,
  parameter logic [WORD_W-1:0] CFG_WORD = 32'h8000_3A5C,
  parameter logic [WORD_W-1:0] READ_CMD = 32'h4000_0000,
  parameter logic [WORD_W-1:0] CFG_MASK = 32'h0000_FFFF
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [WORD_W-1:0]             cmdIn,
  input  logic [NUM_CH-1:0]             sdoIn,
  output logic                          serDataOut,
  output logic [NUM_CH-1:0][WORD_W-1:0] rxWord,
  output logic                          verifyPass,
  output logic                          verifyFail
);

  logic [WORD_W-1:0] txShift;
  logic [NUM_CH-1:0] chMatch;

  assign serDataOut = txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.load) begin
      unique case (strobe.src)
        SRC_CFG:  txShift <= CFG_WORD;
        SRC_READ: txShift <= READ_CMD;
        default:  txShift <= cmdIn;
      endcase
    end else if (strobe.last) begin
      txShift <= '0;
    end else if (strobe.rise) begin
      txShift <= txShift << 1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [WORD_W-1:0] shReg;
    logic [WORD_W-1:0] rxReg;
    logic [WORD_W-1:0] captured;

    assign captured    = {shReg[WORD_W-2:0], sdoIn[ch]};
    assign chMatch[ch] = ((captured ^ CFG_WORD) & CFG_MASK) == '0;
    assign rxWord[ch]  = rxReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg <= '0;
        rxReg <= '0;
      end else if (strobe.rise) begin
        shReg <= captured;
        if (strobe.last) rxReg <= captured;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verifyPass <= 1'b0;
      verifyFail <= 1'b0;
    end else if (strobe.verify) begin
      verifyPass <= &chMatch;
      verifyFail <= ~&chMatch;
    end
  end

endmodule

// File: rtl/fs_adc_host.sv
module fs_adc_host
  import fs_adc_host_pkg::*;
#(
  parameter int                WORD_W   = 32,
  parameter int                CLK_DIV  = 4,
  parameter int                IDLE_GAP = 4,
  parameter logic [WORD_W-1:0] CFG_WORD = 32'h8000_3A5C,
  parameter logic [WORD_W-1:0] READ_CMD = 32'h4000_0000,
  parameter logic [WORD_W-1:0] CFG_MASK = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] cmdIn,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rxWordA,
  output logic [WORD_W-1:0] rxWordB,
  output logic              serClk,
  output logic              frameSyncN,
  output logic              serDataOut,
  input  logic              serDataInA,
  input  logic              serDataInB,
  output logic              verifyPass,
  output logic              verifyFail
);

  localparam int NUM_CH = 2;

  ctrlStrobe_t                   strobe;
  logic [NUM_CH-1:0][WORD_W-1:0] rxWord;

  fs_adc_host_ctrl #(
    .WORD_W  (WORD_W),
    .CLK_DIV (CLK_DIV),
    .IDLE_GAP(IDLE_GAP)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .strobe    (strobe),
    .frameSyncN(frameSyncN),
    .serClk    (serClk),
    .busy      (busy),
    .done      (done)
  );

  fs_adc_host_dp #(
    .WORD_W  (WORD_W),
    .NUM_CH  (NUM_CH),
    .CFG_WORD(CFG_WORD),
    .READ_CMD(READ_CMD),
    .CFG_MASK(CFG_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdIn     (cmdIn),
    .sdoIn     ({serDataInB, serDataInA}),
    .serDataOut(serDataOut),
    .rxWord    (rxWord),
    .verifyPass(verifyPass),
    .verifyFail(verifyFail)
  );

  assign rxWordA = rxWord[0];
  assign rxWordB = rxWord[1];

endmodule

// File: rtl/fs_adc_host_chk.sv
module fs_adc_host_chk #(
  parameter int WORD_W   = 32,
  parameter int CLK_DIV  = 4,
  parameter int IDLE_GAP = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic serClk,
  input logic frameSyncN,
  input logic serDataOut,
  input logic verifyPass,
  input logic verifyFail
);

  localparam int FRAME_CYC = WORD_W * CLK_DIV;
  localparam int LOW_W     = $clog2(FRAME_CYC + 2);
  localparam int HIGH_W    = $clog2(IDLE_GAP + 2);

  logic [LOW_W-1:0]  lowCnt;
  logic [HIGH_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= HIGH_W'(IDLE_GAP);
    end else begin
      lowCnt <= frameSyncN ? '0 : lowCnt + 1'b1;
      if (!frameSyncN)                       highCnt <= '0;
      else if (highCnt < HIGH_W'(IDLE_GAP))  highCnt <= highCnt + 1'b1;
    end
  end

  a_r2_clk_parked: assert property (@(posedge clk) disable iff (!rstN)
    frameSyncN |-> serClk);

  a_r3_frame_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSyncN) |-> (lowCnt == LOW_W'(FRAME_CYC)));

  a_r4_idle_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameSyncN) |-> (highCnt >= HIGH_W'(IDLE_GAP)));

  a_r5_din_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSyncN && $fell(serClk)) |-> $stable(serDataOut));

  a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r10_verify_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(verifyPass && verifyFail));

  a_r10_verify_held: assert property (@(posedge clk) disable iff (!rstN)
    verifyPass |=> verifyPass);

endmodule

bind fs_adc_host fs_adc_host_chk #(
  .WORD_W  (WORD_W),
  .CLK_DIV (CLK_DIV),
  .IDLE_GAP(IDLE_GAP)
) chk (.*);

// File: tb/fs_adc_host_test.sv
module fs_adc_host_test;

  localparam int          WORD_W   = 32;
  localparam int          CLK_DIV  = 4;
  localparam int          IDLE_GAP = 4;
  localparam logic [31:0] CFG_WORD = 32'h8000_3A5C;
  localparam logic [31:0] READ_CMD = 32'h4000_0000;
  localparam logic [31:0] CFG_MASK = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cmdIn = '0;
  logic        serDataInA = 1'b0, serDataInB = 1'b0;
  logic        busy, done, serClk, frameSyncN, serDataOut, verifyPass, verifyFail;
  logic [31:0] rxWordA, rxWordB;

  fs_adc_host #(
    .WORD_W(WORD_W), .CLK_DIV(CLK_DIV), .IDLE_GAP(IDLE_GAP),
    .CFG_WORD(CFG_WORD), .READ_CMD(READ_CMD), .CFG_MASK(CFG_MASK)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .cmdIn(cmdIn), .busy(busy), .done(done),
    .rxWordA(rxWordA), .rxWordB(rxWordB), .serClk(serClk), .frameSyncN(frameSyncN),
    .serDataOut(serDataOut), .serDataInA(serDataInA), .serDataInB(serDataInB),
    .verifyPass(verifyPass), .verifyFail(verifyFail)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0, failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // ---------------- converter models ----------------
  logic [31:0] sampleA = '0, sampleB = '0;
  logic [31:0] txA, txB, rcv, lastCmd;
  logic [15:0] regA = '0, regB = '0;
  logic        replyReg = 1'b0, corruptB = 1'b0, frameOn = 1'b0;
  int fallCnt = 0, bitIdx = 0, frameCnt = 0;
  int fsFallCyc = 0, riseCyc = -1000, lastFallCyc = 0, dinChangeCyc = 0;
  int badLen = 0, badFalls = 0, badFirst = 0, badPer = 0, badPark = 0, badGap = 0, badSetup = 0;
  logic [31:0] cmdLog[$];

  always @(serDataOut) dinChangeCyc = cyc;

  always @(negedge frameSyncN) begin
    if (rstN) begin
      if (cyc - riseCyc < IDLE_GAP) badGap++;
      frameOn   = 1'b1;
      fallCnt   = 0;
      bitIdx    = 31;
      rcv       = '0;
      fsFallCyc = cyc;
      txA = replyReg ? {16'h0000, regA} : sampleA;
      txB = replyReg ? {16'h0000, regB} : sampleB;
      serDataInA = txA[31];
      serDataInB = txB[31];
    end
  end

  always @(negedge serClk) begin
    if (frameOn) begin
      if (fallCnt == 0) begin
        if (cyc - fsFallCyc != CLK_DIV / 2) badFirst++;
      end else begin
        if (cyc - lastFallCyc != CLK_DIV) badPer++;
        if (bitIdx > 0) begin
          bitIdx--;
          serDataInA = txA[bitIdx];
          serDataInB = txB[bitIdx];
        end
      end
      if (cyc - dinChangeCyc < CLK_DIV / 2) badSetup++;
      lastFallCyc = cyc;
      fallCnt++;
      rcv = {rcv[30:0], serDataOut};
    end
  end

  always @(posedge frameSyncN) begin
    if (frameOn) begin
      frameOn = 1'b0;
      if (fallCnt != 32) badFalls++;
      if (cyc - fsFallCyc != 32 * CLK_DIV) badLen++;
      riseCyc = cyc;
      lastCmd = rcv;
      cmdLog.push_back(rcv);
      frameCnt++;
      if (rcv[31]) begin
        regA = rcv[15:0];
        regB = rcv[15:0] ^ (corruptB ? 16'h0001 : 16'h0000);
        replyReg = 1'b1;
      end else begin
        replyReg = 1'b0;
      end
    end
  end

  always @(negedge clk) if (rstN && frameSyncN && !serClk) badPark++;

  // ---------------- scoreboard ----------------
  typedef struct { logic [31:0] cmd; logic [31:0] a; logic [31:0] b; } item_t;
  item_t expQ[$];
  int doneCnt = 0;

  always @(negedge clk) begin
    if (rstN && done) begin
      doneCnt++;
      if (expQ.size() == 0) begin
        check(1'b0, "R7 done without request", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(rxWordA === it.a, "R6 rxWordA", rxWordA, it.a);
        check(rxWordB === it.b, "R6 rxWordB", rxWordB, it.b);
        check(lastCmd === it.cmd, "R5 command bits seen by converter", lastCmd, it.cmd);
        check(busy === 1'b0, "R7 busy low at done", {31'd0, busy}, 32'd0);
      end
    end
  end

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic doXfer(input logic [31:0] cmd, input logic [31:0] wa, input logic [31:0] wb);
    item_t it;
    waitIdle();
    sampleA = wa;
    sampleB = wb;
    it.cmd = cmd; it.a = wa; it.b = wb;
    expQ.push_back(it);
    cmdIn = cmd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmdIn = ~cmd;  // R7: only the value at acceptance counts
    check(busy === 1'b1 && frameSyncN === 1'b0, "R7 busy and frame after start",
          {30'd0, busy, frameSyncN}, 32'd2);
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R7 watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    int f0;
    item_t it;

    repeat (5) @(negedge clk);
    // R1 reset state
    check(frameSyncN === 1'b1 && serClk === 1'b1 && serDataOut === 1'b0, "R1 idle lines in reset",
          {29'd0, frameSyncN, serClk, serDataOut}, 32'd6);
    check(done === 1'b0 && verifyPass === 1'b0 && verifyFail === 1'b0 && busy === 1'b1,
          "R1 status in reset", {28'd0, done, verifyPass, verifyFail, busy}, 32'd1);
    rstN = 1'b1;

    // R9 start-up sequence
    waitIdle();
    check(cmdLog.size() == 2, "R9 start-up frame count", cmdLog.size(), 32'd2);
    if (cmdLog.size() >= 2) begin
      check(cmdLog[0] === CFG_WORD, "R9 first start-up command", cmdLog[0], CFG_WORD);
      check(cmdLog[1] === READ_CMD, "R9 second start-up command", cmdLog[1], READ_CMD);
    end
    check(doneCnt == 0, "R9 no done during start-up", doneCnt, 32'd0);
    // R10 masked compare passes although upper bits differ from CFG_WORD
    check(verifyPass === 1'b1 && verifyFail === 1'b0, "R10 verify pass",
          {30'd0, verifyPass, verifyFail}, 32'd2);

    // R5 R6 R7 host transfers, several patterns
    doXfer(32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001);
    doXfer(32'h3FFF_FFFF, 32'h8000_0000, 32'h0000_0000);
    doXfer(32'h2AAA_5555, 32'h1234_5678, 32'hCAFE_F00D);
    doXfer(32'h0000_0001, 32'h5555_AAAA, 32'hFFFF_FFFE);
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 5; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      doXfer(lfsr & 32'h3FFF_FFFF, lfsr ^ 32'h0F0F_F0F0, ~lfsr);
    end

    // R8 start while busy is ignored
    waitIdle();
    f0 = frameCnt;
    sampleA = 32'hDEAD_0001;
    sampleB = 32'hBEEF_0002;
    it.cmd = 32'h1357_9BDF; it.a = sampleA; it.b = sampleB;
    expQ.push_back(it);
    cmdIn = it.cmd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    cmdIn = 32'h0246_8ACE;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (!done);
    repeat (12) @(negedge clk);
    check(frameCnt == f0 + 1, "R8 no extra frame", frameCnt - f0, 32'd1);
    check(busy === 1'b0 && frameSyncN === 1'b1, "R8 idle after ignored start",
          {30'd0, busy, frameSyncN}, 32'd1);
    check(expQ.size() == 0, "R7 every request completed", expQ.size(), 32'd0);
    check(verifyPass === 1'b1, "R10 result held", {31'd0, verifyPass}, 32'd1);

    // timing observations collected by the models
    check(badLen == 0, "R3 frame length", badLen, 32'd0);
    check(badFalls == 0, "R3 falling edges per frame", badFalls, 32'd0);
    check(badFirst == 0, "R3 first falling edge offset", badFirst, 32'd0);
    check(badPer == 0, "R2 clock period", badPer, 32'd0);
    check(badPark == 0, "R2 clock parked high", badPark, 32'd0);
    check(badGap == 0, "R4 idle gap", badGap, 32'd0);
    check(badSetup == 0, "R5 data-in setup", badSetup, 32'd0);

    // R10 failing readback on converter B
    rstN = 1'b0;
    corruptB = 1'b1;
    replyReg = 1'b0;
    cmdLog.delete();
    repeat (3) @(negedge clk);
    check(verifyPass === 1'b0 && verifyFail === 1'b0, "R1 verify cleared by reset",
          {30'd0, verifyPass, verifyFail}, 32'd0);
    rstN = 1'b1;
    waitIdle();
    check(verifyPass === 1'b0 && verifyFail === 1'b1, "R10 verify fail",
          {30'd0, verifyPass, verifyFail}, 32'd1);
    check(cmdLog.size() == 2, "R9 start-up repeats after reset", cmdLog.size(), 32'd2);

    finishRun();
  end

endmodule